// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

This block gathers a vector of interrupt lines into a pending register and picks the priority level that should interrupt the processor. Each line is set up at elaboration as either level-sensitive or edge-latched. Each line also belongs to one numbered priority level, defined by one membership bit mask per level.

The pending bits are ANDed with an enable register. The resolver then walks the levels from the highest configured one downward and stops once it reaches the processor's current interrupt level. The first level whose mask overlaps the enabled pending bits becomes the pending level, and the request line is raised. If no level qualifies, both outputs read zero.

Edge-latched bits stay set until software writes ones to the clear port. Level-sensitive bits follow their inputs. Lines at or above the configured line count are ignored. The selection is computed combinationally from the registered state and then registered once more before it leaves the block.

Top module: `ilc_top`

## Requirements
- R1: While reset is asserted and on the first edge after it, `pend_vec`, `pend_level` and `irq_req` are all zero, and the enable register is cleared.
- R2: A line below the configured count (default 24) that is high at a rising clock edge shows as a 1 in `pend_vec` right after that edge. For edge-type lines this applies to the first high sample after a low one.
- R3: A level-type line (default: every index i with i mod 4 not equal to 3) that is low at an edge shows as 0 in `pend_vec` right after that edge.
- R4: An edge-type line (default: index i with i mod 4 equal to 3) stays set in `pend_vec` after its input falls, until it is cleared through `sw_clr`.
- R5: A 1 in `sw_clr` clears the matching edge-type pending bit. A rising input on the same edge wins over the clear. `sw_clr` has no effect on level-type bits.
- R6: Lines with index at or above the configured count (default bits 31..24) never set `pend_vec` and have no effect on the outputs.
- R7: Only pending bits whose enable bit is set can cause a request. The enable register loads `en_wdata` on an edge where `en_we` is high.
- R8: `pend_level` is the highest level L with L greater than `cur_level` whose membership mask overlaps the enabled pending bits. By default line i belongs to level (i mod 6)+1, and there are 6 levels.
- R9: When no level above `cur_level` qualifies (this includes any `cur_level` of 6 or 7), `pend_level` is 0 and `irq_req` is low.
- R10: `pend_level` and `irq_req` are registered. They reflect the pending and enable register contents and `cur_level` as they were at the previous edge. `irq_req` is high exactly when `pend_level` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | IRQ_W | Raw interrupt lines, active high |
| sw_clr | input | IRQ_W | Write-one-to-clear strobe for edge-type pending bits |
| en_we | input | 1 | Load strobe for the enable register |
| en_wdata | input | IRQ_W | New enable register value |
| cur_level | input | LVL_W | Processor's current interrupt level |
| pend_vec | output | IRQ_W | Pending register contents |
| pend_level | output | LVL_W | Selected level, 0 when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
A line change at one clock edge shows up in `pend_vec` immediately after that edge. It reaches `pend_level` and `irq_req` after the following edge, two edges in total. A change of `cur_level`, or of the enable register contents, reaches the outputs one edge after it has been sampled. The bench drives all inputs 1 ns after a rising edge. At every edge it advances a cycle model that computes the registered outputs from the state before that edge, and it compares all outputs 1 ns after the edge. The directed checks on levels are taken only after two idle edges, so the state they look at has settled.

// File: rtl/ilc_pkg.sv
`timescale 1ns/1ps
package ilc_pkg;

   // Width needed to carry level numbers 0..n
   function automatic int level_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ilc_capture.sv
`timescale 1ns/1ps
module ilc_capture #(
   parameter int IRQ_W = 32,
   parameter int NUM_IRQ = 24,
   parameter logic [IRQ_W-1:0] EDGE_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] irq_in,
   input  logic [IRQ_W-1:0] clr,
   output logic [IRQ_W-1:0] pend_o
);

   for (genvar i = 0; i < IRQ_W; i++) begin : g_line
      if (i >= NUM_IRQ) begin : g_absent
         assign pend_o[i] = 1'b0;
      end else if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               bit_q  <= 1'b0;
            end else begin
               prev_q <= irq_in[i];
               if (irq_in[i] && !prev_q) begin
                  bit_q <= 1'b1;
               end else if (clr[i]) begin
                  bit_q <= 1'b0;
               end
            end
         end
         assign pend_o[i] = bit_q;
      end else begin : g_level
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else begin
               bit_q <= irq_in[i];
            end
         end
         assign pend_o[i] = bit_q;
      end
   end

endmodule

// File: rtl/ilc_enable.sv
`timescale 1ns/1ps
module ilc_enable #(
   parameter int IRQ_W = 32,
   parameter int NUM_IRQ = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IRQ_W-1:0] wdata,
   output logic [IRQ_W-1:0] en_o
);

   localparam logic [IRQ_W-1:0] VALID = (NUM_IRQ >= IRQ_W) ? '1 :
                                        ((IRQ_W'(1) << NUM_IRQ) - IRQ_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o <= '0;
      end else if (we) begin
         en_o <= wdata & VALID;
      end
   end

endmodule

// File: rtl/ilc_resolve.sv
`timescale 1ns/1ps
module ilc_resolve #(
   parameter int IRQ_W = 32,
   parameter int NUM_LEVELS = 6,
   parameter int LVL_W = 3,
   parameter logic [NUM_LEVELS*IRQ_W-1:0] LEVEL_MASKS = '0
) (
   input  logic [IRQ_W-1:0] eff,
   input  logic [LVL_W-1:0] cur_level,
   output logic [LVL_W-1:0] sel_level
);

   logic [NUM_LEVELS:1] hit;

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
      assign hit[l] = |(LEVEL_MASKS[(l-1)*IRQ_W +: IRQ_W] & eff) &&
                      (LVL_W'(l) > cur_level);
   end

   always_comb begin
      sel_level = '0;
      for (int l = 1; l <= NUM_LEVELS; l++) begin
         if (hit[l]) begin
            sel_level = LVL_W'(l);
         end
      end
   end

endmodule

// File: rtl/ilc_top.sv
`timescale 1ns/1ps
module ilc_top #(
   parameter int IRQ_W = 32,
   parameter int NUM_IRQ = 24,
   parameter int NUM_LEVELS = 6,
   parameter int LVL_W = ilc_pkg::level_width(NUM_LEVELS),
   parameter logic [IRQ_W-1:0] EDGE_MASK = 32'h8888_8888,
   parameter logic [NUM_LEVELS*IRQ_W-1:0] LEVEL_MASKS = {
      32'h2082_0820, 32'h1041_0410, 32'h0820_8208,
      32'h0410_4104, 32'h8208_2082, 32'h4104_1041}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] irq_in,
   input  logic [IRQ_W-1:0] sw_clr,
   input  logic             en_we,
   input  logic [IRQ_W-1:0] en_wdata,
   input  logic [LVL_W-1:0] cur_level,
   output logic [IRQ_W-1:0] pend_vec,
   output logic [LVL_W-1:0] pend_level,
   output logic             irq_req
);

   if (NUM_IRQ < 1 || NUM_IRQ > IRQ_W) begin : g_bad_count
      $error("ilc_top: NUM_IRQ must lie in 1..IRQ_W");
   end
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("ilc_top: NUM_LEVELS must be at least 1");
   end
   if ((1 << LVL_W) <= NUM_LEVELS) begin : g_bad_lvlw
      $error("ilc_top: LVL_W too narrow for NUM_LEVELS");
   end

   logic [IRQ_W-1:0] en_q;
   logic [IRQ_W-1:0] eff;
   logic [LVL_W-1:0] sel_level;

   ilc_capture #(
      .IRQ_W(IRQ_W), .NUM_IRQ(NUM_IRQ), .EDGE_MASK(EDGE_MASK)
   ) cap_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(sw_clr), .pend_o(pend_vec)
   );

   ilc_enable #(
      .IRQ_W(IRQ_W), .NUM_IRQ(NUM_IRQ)
   ) en_i (
      .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(en_wdata), .en_o(en_q)
   );

   assign eff = pend_vec & en_q;

   ilc_resolve #(
      .IRQ_W(IRQ_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .LEVEL_MASKS(LEVEL_MASKS)
   ) res_i (
      .eff(eff), .cur_level(cur_level), .sel_level(sel_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_level <= '0;
         irq_req    <= 1'b0;
      end else begin
         pend_level <= sel_level;
         irq_req    <= |sel_level;
      end
   end

endmodule

// File: rtl/ilc_checker.sv
`timescale 1ns/1ps
module ilc_checker #(
   parameter int IRQ_W = 32,
   parameter int NUM_IRQ = 24,
   parameter int LVL_W = 3,
   parameter logic [IRQ_W-1:0] EDGE_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IRQ_W-1:0] irq_in,
   input logic [IRQ_W-1:0] sw_clr,
   input logic [LVL_W-1:0] cur_level,
   input logic [IRQ_W-1:0] pend_vec,
   input logic [IRQ_W-1:0] en_q,
   input logic [LVL_W-1:0] pend_level,
   input logic             irq_req
);

   p_reset_clears_r1: assert property (@(posedge clk)
      !rst_n |=> (pend_vec == '0 && pend_level == '0 && !irq_req));

   p_req_tracks_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (pend_level != '0));

   p_above_current_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && irq_req) |-> (pend_level > $past(cur_level)));

   p_enabled_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && irq_req) |-> (|$past(pend_vec & en_q)));

   p_idle_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(pend_vec & en_q) == '0)) |-> !irq_req);

   for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
      if (i >= NUM_IRQ) begin : g_oob
         p_oob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !pend_vec[i]);
      end else if (EDGE_MASK[i]) begin : g_edge
         p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pend_vec[i]) && !$past(sw_clr[i])) |-> pend_vec[i]);
      end else begin : g_level
         p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (pend_vec[i] == $past(irq_in[i])));
      end
   end

endmodule

bind ilc_top ilc_checker #(
   .IRQ_W(IRQ_W), .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .EDGE_MASK(EDGE_MASK)
) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sw_clr(sw_clr),
   .cur_level(cur_level), .pend_vec(pend_vec), .en_q(en_q),
   .pend_level(pend_level), .irq_req(irq_req)
);

// File: tb/ilc_top_tb_top.sv
`timescale 1ns/1ps
module ilc_top_tb_top;

   localparam int IRQ_W = 32;
   localparam int NUM_IRQ = 24;
   localparam int NL = 6;
   localparam int LW = 3;
   localparam logic [31:0] VALID = 32'h00FF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   irq_in = '0;
   logic [31:0]   sw_clr = '0;
   logic          en_we = 1'b0;
   logic [31:0]   en_wdata = '0;
   logic [LW-1:0] cur_level = '0;
   logic [31:0]   pend_vec;
   logic [LW-1:0] pend_level;
   logic          irq_req;

   always #2 clk = ~clk;

   ilc_top dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sw_clr(sw_clr),
      .en_we(en_we), .en_wdata(en_wdata), .cur_level(cur_level),
      .pend_vec(pend_vec), .pend_level(pend_level), .irq_req(irq_req)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0]   m_pend = '0;
   logic [31:0]   m_en = '0;
   logic [31:0]   m_prev = '0;
   logic [LW-1:0] m_lvl = '0;
   logic          m_req = 1'b0;

   function automatic logic [31:0] lvl_mask(int l);
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) if ((i % 6) + 1 == l) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [LW-1:0] pick(logic [31:0] p, logic [31:0] e, logic [LW-1:0] cur);
      for (int l = NL; l >= 1; l--) begin
         if (l > int'(cur) && (lvl_mask(l) & p & e) != 0) return LW'(l);
      end
      return '0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One clock edge: advance the model with the inputs sampled at the edge
   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         m_pend = '0; m_en = '0; m_prev = '0; m_lvl = '0; m_req = 1'b0;
      end else begin
         m_lvl = pick(m_pend, m_en, cur_level);
         m_req = (m_lvl != 0);
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (i % 4 == 3) begin
               if (irq_in[i] && !m_prev[i]) m_pend[i] = 1'b1;
               else if (sw_clr[i]) m_pend[i] = 1'b0;
            end else begin
               m_pend[i] = irq_in[i];
            end
         end
         m_prev = irq_in;
         if (en_we) m_en = en_wdata & VALID;
      end
      #1;
      chk("R2 model pend_vec", pend_vec, m_pend);
      chk("R8 model pend_level", 32'(pend_level), 32'(m_lvl));
      chk("R10 model irq_req", 32'(irq_req), 32'(m_req));
   endtask

   task automatic drive(logic [31:0] in, logic [31:0] clr, logic we,
                        logic [31:0] wd, logic [LW-1:0] cur);
      irq_in = in; sw_clr = clr; en_we = we; en_wdata = wd; cur_level = cur;
      tick();
      sw_clr = '0; en_we = 1'b0;
   endtask

   initial begin
      #800000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'h5EED_1234);
      #1;
      // R1 reset state
      tick(); tick(); tick();
      chk("R1 pend_vec at reset", pend_vec, 32'h0);
      chk("R1 pend_level at reset", 32'(pend_level), 32'h0);
      chk("R1 irq_req at reset", 32'(irq_req), 32'h0);
      rst_n = 1'b1;
      drive(32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 3'd0);

      // R2 level line 0 (level 1) sets
      drive(32'h1, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R2 bit0 set", 32'(pend_vec[0]), 32'h1);
      drive(32'h1, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R8 level 1 from bit0", 32'(pend_level), 32'h1);
      chk("R10 req with level 1", 32'(irq_req), 32'h1);
      // R3 level line clears
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R3 bit0 cleared", 32'(pend_vec[0]), 32'h0);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);

      // R4 edge line 3 (level 4) latches
      drive(32'h8, 32'h0, 1'b0, 32'h0, 3'd0);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R4 bit3 latched", 32'(pend_vec[3]), 32'h1);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R8 level 4 from bit3", 32'(pend_level), 32'h4);

      // R5 clear edge bit, level bit unaffected, rising edge beats clear
      drive(32'h1, 32'h0, 1'b0, 32'h0, 3'd0);
      drive(32'h1, 32'h9, 1'b0, 32'h0, 3'd0);
      chk("R5 clear edge keep level", pend_vec, 32'h1);
      drive(32'h80, 32'h80, 1'b0, 32'h0, 3'd0);
      chk("R5 rise beats clear", 32'(pend_vec[7]), 32'h1);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);

      // R6 lines 31..24 ignored
      drive(32'hFF00_0000, 32'h0, 1'b0, 32'h0, 3'd0);
      drive(32'hFF00_0000, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R6 upper pend bits", pend_vec & 32'hFF00_0000, 32'h0);
      chk("R6 pending only bit7", pend_vec, 32'h80);
      chk("R6 level from bit7 only", 32'(pend_level), 32'h2);

      // R7 disable bit7 removes the request
      drive(32'h0, 32'h0, 1'b1, 32'h00FF_FF7F, 3'd0);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R7 disabled pending no req", 32'(irq_req), 32'h0);
      chk("R7 disabled pending level", 32'(pend_level), 32'h0);
      chk("R7 bit still pending", 32'(pend_vec[7]), 32'h1);

      // R8/R9 priority against current level: bit7 level 2, bit5 level 6
      drive(32'h20, 32'h0, 1'b1, 32'hFFFF_FFFF, 3'd5);
      drive(32'h20, 32'h0, 1'b0, 32'h0, 3'd5);
      drive(32'h20, 32'h0, 1'b0, 32'h0, 3'd5);
      chk("R8 level 6 above cur 5", 32'(pend_level), 32'h6);
      drive(32'h20, 32'h0, 1'b0, 32'h0, 3'd6);
      chk("R9 cur 6 blocks all", 32'(pend_level), 32'h0);
      chk("R9 cur 6 no req", 32'(irq_req), 32'h0);
      drive(32'h20, 32'h0, 1'b0, 32'h0, 3'd1);
      chk("R8 highest of two wins", 32'(pend_level), 32'h6);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd1);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd1);
      chk("R8 falls to level 2", 32'(pend_level), 32'h2);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd2);
      chk("R9 equal level not taken", 32'(irq_req), 32'h0);
      drive(32'h0, 32'h0, 1'b0, 32'h0, 3'd7);
      chk("R9 cur 7 none", 32'(pend_level), 32'h0);
      drive(32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0, 3'd0);
      chk("R5 clear all edge bits", pend_vec, 32'h0);

      // Random phase
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] in_v;
         logic [31:0] clr_v;
         in_v = irq_in ^ ($urandom() & $urandom() & $urandom());
         clr_v = (($urandom() % 4) == 0) ? $urandom() : 32'h0;
         if (($urandom() % 16) == 0)
            drive(in_v, clr_v, 1'b1, $urandom(), LW'($urandom()));
         else
            drive(in_v, clr_v, 1'b0, 32'h0, (($urandom() % 8) == 0) ? LW'($urandom()) : cur_level);
      end

      // Reset again mid-run: R1
      rst_n = 1'b0;
      tick();
      chk("R1 pend_vec after reset", pend_vec, 32'h0);
      chk("R1 irq_req after reset", 32'(irq_req), 32'h0);
      rst_n = 1'b1;
      drive(32'h1, 32'h0, 1'b0, 32'h0, 3'd0);
      drive(32'h1, 32'h0, 1'b0, 32'h0, 3'd0);
      chk("R1 enable cleared by reset", 32'(irq_req), 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule